// File: doc/BRIEF.md
# Flash Program Timebase Divider

This block produces the slow pacing tick that flash erase and program sequencing counts against. The tick comes from the CPU core clock, divided down by a factor picked with a 4-bit code, so that its period lands between one and two microseconds at the core clock in use. The smallest factor is 2, so self-programming needs a core clock of at least 1 MHz. A period shorter than one microsecond leaves the cells under-programmed. A period longer than two microseconds over-stresses them.

The sequencer picks a code and pulses `op_start` while `op_busy` is low. It then holds `op_busy` high for the whole erase or program operation. The block latches the factor at the start pulse and keeps it for the whole operation, because the timing must not shift mid-operation. While the operation runs, the block emits one single-cycle tick per divided period. A start request with one of the three unsupported codes raises `cfg_err` and produces no ticks. The factor in use is visible on `div_held`.

Top module: `flash_tick_div`

## Requirements
- R1: A start (`op_start`=1 while `op_busy`=0) with code c in 0..12 loads `div_held` on the next cycle with: 0→2, 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 7→24, 8→32, 9→48, 10→64, 11→96, 12→128.
- R2: A start with code 13, 14 or 15 sets `cfg_err`, loads `div_held` with 0, and no tick appears for that operation.
- R3: With `op_busy` high from the cycle after the start, the first tick is high in the cycle that follows the N-th rising edge after the start edge, where N is the latched factor.
- R4: While the operation runs, `tick` is high for exactly one cycle in every N cycles.
- R5: While `op_busy` is high, changes on `div_code` and any `op_start` pulse are ignored: `div_held` and the tick pattern are unchanged.
- R6: `tick` is low in any cycle where `op_busy` is low.
- R7: A start with a supported code clears `cfg_err`.
- R8: A synchronous reset clears `cfg_err`, `div_held` and `tick`.
- R9: Once `op_busy` has dropped, raising it again without a new start produces no ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU core clock |
| rst | input | 1 | Synchronous active-high reset |
| div_code | input | 4 | Divisor select code |
| op_start | input | 1 | One-cycle request to begin an erase or program operation |
| op_busy | input | 1 | High for the whole operation |
| tick | output | 1 | Single-cycle time-base pulse |
| div_held | output | 9 | Divisor latched for the current operation (0 when none is valid) |
| cfg_err | output | 1 | Last start request used an unsupported code |

## Verification
The hardest case to reach from the ports is a start request, or a new code, that arrives in the middle of a running operation. A correct block must ignore both, so nothing at the outputs shows that they happened. The stimulus therefore changes `div_code` at random on every cycle of each operation. In directed runs it also pulses `op_start` partway through a long division. The bench then checks that the tick positions still follow the first latched factor exactly.

// File: rtl/flash_tick_pkg.sv
package flash_tick_pkg;
  localparam int CODE_W       = 4;
  localparam int DIV_W        = 9;
  localparam int LAST_OK_CODE = 12;

  // Factor for a code: even codes give 2<<k, odd codes give 3<<k, k = code/2.
  function automatic logic [DIV_W-1:0] code_to_div(input logic [CODE_W-1:0] c);
    logic [DIV_W-1:0] base;
    base = c[0] ? DIV_W'(3) : DIV_W'(2);
    return base << c[CODE_W-1:1];
  endfunction
endpackage

// File: rtl/flash_tick_decode.sv
module flash_tick_decode
  import flash_tick_pkg::*;
#(
  parameter int CW      = CODE_W,
  parameter int DW      = DIV_W,
  parameter int LAST_OK = LAST_OK_CODE
) (
  input  logic [CW-1:0] code,
  output logic [DW-1:0] div_val,
  output logic          reserved
);
  always_comb begin
    reserved = (int'(code) > LAST_OK);
    div_val  = reserved ? '0 : DW'(code_to_div(CODE_W'(code)));
  end
endmodule

// File: rtl/flash_tick_ctrl.sv
module flash_tick_ctrl #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_start,
  input  logic          op_busy,
  input  logic [DW-1:0] div_val,
  input  logic          reserved,
  output logic          run,
  output logic          launch,
  output logic [DW-1:0] div_held,
  output logic          cfg_err
);
  logic accept;

  assign accept = op_start && !op_busy;
  assign launch = accept && !reserved;

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      div_held <= '0;
      cfg_err  <= 1'b0;
    end else if (accept) begin
      if (reserved) begin
        run      <= 1'b0;
        div_held <= '0;
        cfg_err  <= 1'b1;
      end else begin
        run      <= 1'b1;
        div_held <= div_val;
        cfg_err  <= 1'b0;
      end
    end else if (!op_busy) begin
      run <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_tick_count.sv
module flash_tick_count #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          run,
  input  logic          op_busy,
  input  logic [DW-1:0] div_held,
  output logic          tick_r
);
  logic [DW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == div_held - DW'(1));

  always_ff @(posedge clk) begin
    if (rst || launch || !run || !op_busy) begin
      cnt    <= '0;
      tick_r <= 1'b0;
    end else if (wrap) begin
      cnt    <= '0;
      tick_r <= 1'b1;
    end else begin
      cnt    <= cnt + DW'(1);
      tick_r <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_tick_div.sv
module flash_tick_div
  import flash_tick_pkg::*;
#(
  parameter int CW      = CODE_W,
  parameter int DW      = DIV_W,
  parameter int LAST_OK = LAST_OK_CODE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] div_code,
  input  logic          op_start,
  input  logic          op_busy,
  output logic          tick,
  output logic [DW-1:0] div_held,
  output logic          cfg_err
);
  logic [DW-1:0] div_val;
  logic          reserved;
  logic          run;
  logic          launch;
  logic          tick_r;

  flash_tick_decode #(.CW(CW), .DW(DW), .LAST_OK(LAST_OK)) u_dec (
    .code    (div_code),
    .div_val (div_val),
    .reserved(reserved)
  );

  flash_tick_ctrl #(.DW(DW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .op_start(op_start),
    .op_busy (op_busy),
    .div_val (div_val),
    .reserved(reserved),
    .run     (run),
    .launch  (launch),
    .div_held(div_held),
    .cfg_err (cfg_err)
  );

  flash_tick_count #(.DW(DW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .launch  (launch),
    .run     (run),
    .op_busy (op_busy),
    .div_held(div_held),
    .tick_r  (tick_r)
  );

  assign tick = tick_r && op_busy;
endmodule

// File: rtl/flash_tick_div_chk.sv
module flash_tick_div_chk #(
  parameter int CW      = 4,
  parameter int DW      = 9,
  parameter int LAST_OK = 12
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] div_code,
  input logic          op_start,
  input logic          op_busy,
  input logic          tick,
  input logic [DW-1:0] div_held,
  input logic          cfg_err
);
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!cfg_err && div_held == '0 && !tick));

  assert_hold_busy_R5: assert property (@(posedge clk) disable iff (rst)
    op_busy |=> $stable(div_held));

  assert_single_tick_R4: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  assert_no_tick_on_err_R2: assert property (@(posedge clk) disable iff (rst)
    tick |-> (!cfg_err && div_held != '0));

  assert_err_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_err) |-> ($past(op_start) && !$past(op_busy) && int'($past(div_code)) > LAST_OK));

  assert_err_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (op_start && !op_busy && int'(div_code) <= LAST_OK) |=> !cfg_err);

  always_comb begin
    if (!rst && !op_busy) begin
      assert_idle_quiet_R6: assert (!tick);
    end
  end
endmodule

bind flash_tick_div flash_tick_div_chk #(.CW(CW), .DW(DW), .LAST_OK(LAST_OK)) u_chk (
  .clk(clk), .rst(rst), .div_code(div_code), .op_start(op_start),
  .op_busy(op_busy), .tick(tick), .div_held(div_held), .cfg_err(cfg_err)
);

// File: tb/tb_flash_tick_div.sv
module tb_flash_tick_div;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] div_code;
  logic       op_start;
  logic       op_busy;
  logic       tick;
  logic [8:0] div_held;
  logic       cfg_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  flash_tick_div dut (
    .clk(clk), .rst(rst), .div_code(div_code), .op_start(op_start),
    .op_busy(op_busy), .tick(tick), .div_held(div_held), .cfg_err(cfg_err)
  );

  function automatic int exp_div(input int c);
    case (c)
      0: return 2;    1: return 3;    2: return 4;    3: return 6;
      4: return 8;    5: return 12;   6: return 16;   7: return 24;
      8: return 32;   9: return 48;   10: return 64;  11: return 96;
      12: return 128;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // One operation: start with code c, run len cycles busy; optional mid start.
  task automatic run_op(input int c, input int len, input int mid_at);
    int n;
    n = exp_div(c);
    @(negedge clk);
    div_code = 4'(c); op_start = 1'b1; op_busy = 1'b0;
    @(negedge clk);
    op_start = 1'b0; op_busy = 1'b1;
    check((n == 0) ? "R2 div_held" : "R1 div_held", int'(div_held), n);
    check((n == 0) ? "R2 cfg_err" : "R7 cfg_err", int'(cfg_err), (n == 0) ? 1 : 0);
    for (int i = 1; i <= len; i++) begin
      div_code = 4'($urandom_range(0, 15));
      op_start = (i == mid_at);
      @(negedge clk);
      op_start = 1'b0;
      if (n == 0) check("R2 tick", int'(tick), 0);
      else if (i == n) check("R3 first tick", int'(tick), 1);
      else check("R4 tick", int'(tick), (i % n == 0) ? 1 : 0);
      if (mid_at > 0) check("R5 div_held", int'(div_held), n);
    end
    op_busy = 1'b0;
    #1 check("R6 tick idle", int'(tick), 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; div_code = 4'd0; op_start = 1'b0; op_busy = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 cfg_err", int'(cfg_err), 0);
    check("R8 div_held", int'(div_held), 0);
    check("R8 tick", int'(tick), 0);
    rst = 1'b0;

    for (int c = 0; c < 16; c++) run_op(c, 2 * ((exp_div(c) > 0) ? exp_div(c) : 8) + 1, 0);
    run_op(2, 20, 5);     // R5 start while busy
    run_op(7, 60, 13);
    run_op(0, 12, 1);

    // R9: busy again without a start
    @(negedge clk); op_busy = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R9 tick", int'(tick), 0);
    end
    op_busy = 1'b0;

    // R2 then R7 back-to-back
    run_op(14, 10, 0);
    run_op(1, 9, 0);

    for (int k = 0; k < 25; k++) begin
      int c, n;
      c = $urandom_range(0, 15);
      n = exp_div(c);
      run_op(c, ((n > 0) ? n : 4) * $urandom_range(1, 3) + $urandom_range(0, 3),
             ($urandom_range(0, 3) == 0) ? $urandom_range(1, 4) : 0);
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    // R8 reset mid-operation
    @(negedge clk); div_code = 4'd3; op_start = 1'b1;
    @(negedge clk); op_start = 1'b0; op_busy = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R8 div_held", int'(div_held), 0);
    check("R8 tick", int'(tick), 0);
    rst = 1'b0; op_busy = 1'b0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule